// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects interrupt events for a storage-card host controller and turns them into one interrupt line. Each event source pulses for one clock. The pulse is caught in a local status register whether or not it is enabled. A local enable register selects which caught events count. The enabled result is latched into bit 0 of a global status register. Bit 1 of that register belongs to a neighbouring controller, which reports through its own pulse input.

The global register has two one-bit enables. The status enable controls whether software can see the global bits on a read. The signal enable, together with the status enable, gates the interrupt output. Software clears both status registers by writing ones. It can clear stale local events before turning their enables on.

Top module: `cardirq_hub`

## Requirements
- R1: After the active-low reset, every register reads zero and `irq_o` is low.
- R2: A one-cycle pulse on `card_evt[i]` sets local status bit i at the next clock edge, whatever the local enable holds. Only bits 0,1,2,3,8,9,10,11 exist (mask 0xF0F). The other local bits and bits 12-31 always read 0. Local status is at address 0x004.
- R3: Writing address 0x004 clears each local status bit written with 1 and leaves each bit written with 0 unchanged.
- R4: If a local event pulse and a write of 1 to the same local status bit occur in the same cycle, the bit is set after the edge.
- R5: The local enable at address 0x008 stores the written bits inside mask 0xF0F and reads them back. Other bits read 0.
- R6: While any local status bit is 1 with its enable bit 1, global status bit 0 is set at the next edge. It stays set until software clears it by writing 1 to bit 0 at 0x800. If the enabled local condition still holds during the clearing write, the bit stays set.
- R7: A one-cycle pulse on `peer_evt` sets global status bit 1 at the next edge. Writing 1 to bit 1 at 0x800 clears it.
- R8: A read of 0x800 returns the latched global bits when the status-enable bit is 1, and returns 0 when it is 0.
- R9: The status enable (address 0x804) and the signal enable (address 0x808) each store bit 0 of their own write and read back as bit 0.
- R10: `irq_o` is 1 exactly when a global status bit is 1 and both enables are 1. It follows register values with no extra cycle.
- R11: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Register byte address, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| card_evt | input | 12 | Event pulses from the local sources, one bit per source |
| peer_evt | input | 1 | Summary pulse from the neighbouring controller |
| irq_o | output | 1 | Interrupt output |

## Verification
A local status bit that is stuck or mis-cleared shows up on the next read of 0x004. Through the summary path, it also shows on global bit 0 and on `irq_o` one cycle later. A lost summary latch or a swapped enable shows on the output. Either `irq_o` stays low after an enabled event, or it rises while an enable is off, within two clocks of the event. Set-versus-clear priority is only visible in the cycle where both happen. For that reason the bench forces such collisions and reads the bit back right after.

// File: rtl/cirq_pkg.sv
`timescale 1ns/1ps
package cirq_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_LSTS = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_LEN  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_GSTS = 12'h800;
  localparam logic [ADDR_W-1:0] OFF_GSE  = 12'h804;
  localparam logic [ADDR_W-1:0] OFF_GSIG = 12'h808;

  // local source bit positions (decoded by software)
  localparam int B_CARD = 0;
  localparam int B_STCH = 1;
  localparam int B_MEMM = 2;
  localparam int B_IOM  = 3;
  localparam int B_IDEM = 8;
  localparam int B_XERR = 9;
  localparam int B_BUFA = 10;
  localparam int B_DONE = 11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LSTS, SEL_LEN, SEL_GSTS, SEL_GSE, SEL_GSIG
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_LSTS: return SEL_LSTS;
      OFF_LEN:  return SEL_LEN;
      OFF_GSTS: return SEL_GSTS;
      OFF_GSE:  return SEL_GSE;
      OFF_GSIG: return SEL_GSIG;
      default:  return SEL_NONE;
    endcase
  endfunction

  // sticky bit: a new event beats a clear in the same cycle
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/cirq_regport.sv
`timescale 1ns/1ps
module cirq_regport
  import cirq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LOCAL_W  = 12,
  parameter int GLOBAL_W = 2
) (
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [LOCAL_W-1:0]  lsts,
  input  logic [LOCAL_W-1:0]  len,
  input  logic [GLOBAL_W-1:0] gsts,
  input  logic                gse,
  input  logic                gsig,
  output logic                wr_lsts,
  output logic                wr_len,
  output logic                wr_gsts,
  output logic                wr_gse,
  output logic                wr_gsig,
  output logic [DATA_W-1:0]   reg_rdata
);
  localparam int LPAD = DATA_W - LOCAL_W;
  localparam int GPAD = DATA_W - GLOBAL_W;

  reg_sel_e sel;
  assign sel = decode_addr(reg_addr);

  assign wr_lsts = reg_wr && (sel == SEL_LSTS);
  assign wr_len  = reg_wr && (sel == SEL_LEN);
  assign wr_gsts = reg_wr && (sel == SEL_GSTS);
  assign wr_gse  = reg_wr && (sel == SEL_GSE);
  assign wr_gsig = reg_wr && (sel == SEL_GSIG);

  always_comb begin
    case (sel)
      SEL_LSTS: reg_rdata = {{LPAD{1'b0}}, lsts};
      SEL_LEN:  reg_rdata = {{LPAD{1'b0}}, len};
      SEL_GSTS: reg_rdata = {{GPAD{1'b0}}, gsts & {GLOBAL_W{gse}}};
      SEL_GSE:  reg_rdata = {{(DATA_W-1){1'b0}}, gse};
      SEL_GSIG: reg_rdata = {{(DATA_W-1){1'b0}}, gsig};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cirq_local_bank.sv
`timescale 1ns/1ps
module cirq_local_bank
  import cirq_pkg::*;
#(
  parameter int               LOCAL_W    = 12,
  parameter logic [LOCAL_W-1:0] LOCAL_MASK = 12'hF0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOCAL_W-1:0] evt,
  input  logic               wr_sts,
  input  logic               wr_en,
  input  logic [LOCAL_W-1:0] wdata,
  output logic [LOCAL_W-1:0] sts,
  output logic [LOCAL_W-1:0] en,
  output logic               pend
);
  for (genvar i = 0; i < LOCAL_W; i++) begin : g_bit
    if (LOCAL_MASK[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sts[i] <= 1'b0;
          en[i]  <= 1'b0;
        end else begin
          sts[i] <= sticky_next(sts[i], evt[i], wr_sts & wdata[i]);
          if (wr_en) en[i] <= wdata[i];
        end
      end
    end else begin : g_tie
      assign sts[i] = 1'b0;
      assign en[i]  = 1'b0;
    end
  end

  assign pend = |(sts & en);
endmodule

// File: rtl/cirq_global_bank.sv
`timescale 1ns/1ps
module cirq_global_bank
  import cirq_pkg::*;
#(
  parameter int GLOBAL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GLOBAL_W-1:0] set_vec,
  input  logic                wr_sts,
  input  logic                wr_gse,
  input  logic                wr_gsig,
  input  logic [GLOBAL_W-1:0] wdata,
  output logic [GLOBAL_W-1:0] gsts,
  output logic                gse,
  output logic                gsig,
  output logic                irq
);
  for (genvar j = 0; j < GLOBAL_W; j++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) gsts[j] <= 1'b0;
      else        gsts[j] <= sticky_next(gsts[j], set_vec[j], wr_sts & wdata[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gse  <= 1'b0;
      gsig <= 1'b0;
    end else begin
      if (wr_gse)  gse  <= wdata[0];
      if (wr_gsig) gsig <= wdata[0];
    end
  end

  assign irq = (|gsts) & gse & gsig;
endmodule

// File: rtl/cardirq_hub.sv
`timescale 1ns/1ps
module cardirq_hub
  import cirq_pkg::*;
#(
  parameter int                 DATA_W     = 32,
  parameter int                 LOCAL_W    = 12,
  parameter int                 GLOBAL_W   = 2,
  parameter logic [LOCAL_W-1:0] LOCAL_MASK = 12'hF0F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [LOCAL_W-1:0]    card_evt,
  input  logic [GLOBAL_W-2:0]   peer_evt,
  output logic                  irq_o
);
  logic [LOCAL_W-1:0]  lsts, len;
  logic [GLOBAL_W-1:0] gsts;
  logic                gse, gsig, local_pend;
  logic                wr_lsts, wr_len, wr_gsts, wr_gse, wr_gsig;
  logic [GLOBAL_W-1:0] gset;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:LOCAL_W];
  assign gset = {peer_evt, local_pend};

  cirq_regport #(.DATA_W(DATA_W), .LOCAL_W(LOCAL_W), .GLOBAL_W(GLOBAL_W)) u_port (
    .reg_wr(reg_wr), .reg_addr(reg_addr),
    .lsts(lsts), .len(len), .gsts(gsts), .gse(gse), .gsig(gsig),
    .wr_lsts(wr_lsts), .wr_len(wr_len), .wr_gsts(wr_gsts),
    .wr_gse(wr_gse), .wr_gsig(wr_gsig), .reg_rdata(reg_rdata)
  );

  cirq_local_bank #(.LOCAL_W(LOCAL_W), .LOCAL_MASK(LOCAL_MASK)) u_local (
    .clk(clk), .rst_n(rst_n), .evt(card_evt),
    .wr_sts(wr_lsts), .wr_en(wr_len), .wdata(reg_wdata[LOCAL_W-1:0]),
    .sts(lsts), .en(len), .pend(local_pend)
  );

  cirq_global_bank #(.GLOBAL_W(GLOBAL_W)) u_global (
    .clk(clk), .rst_n(rst_n), .set_vec(gset),
    .wr_sts(wr_gsts), .wr_gse(wr_gse), .wr_gsig(wr_gsig),
    .wdata(reg_wdata[GLOBAL_W-1:0]),
    .gsts(gsts), .gse(gse), .gsig(gsig), .irq(irq_o)
  );
endmodule

// File: rtl/cirq_chk.sv
`timescale 1ns/1ps
module cirq_chk
  import cirq_pkg::*;
#(
  parameter int                 DATA_W     = 32,
  parameter int                 LOCAL_W    = 12,
  parameter int                 GLOBAL_W   = 2,
  parameter logic [LOCAL_W-1:0] LOCAL_MASK = 12'hF0F
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [LOCAL_W-1:0]  card_evt,
  input logic [GLOBAL_W-2:0] peer_evt,
  input logic                irq_o,
  input logic [LOCAL_W-1:0]  lsts,
  input logic [LOCAL_W-1:0]  len,
  input logic [GLOBAL_W-1:0] gsts,
  input logic                gse,
  input logic                gsig
);
  logic            lwr;
  logic [LOCAL_W-1:0] wlo;
  assign lwr = reg_wr && (reg_addr == OFF_LSTS);
  assign wlo = reg_wdata[LOCAL_W-1:0];

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lsts == '0 && len == '0 && gsts == '0 && !gse && !gsig && !irq_o)); // R1
  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lsts & $past(card_evt & LOCAL_MASK)) == $past(card_evt & LOCAL_MASK))); // R2
  AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lwr |=> ((lsts & $past(wlo & ~card_evt)) == '0)); // R3
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    lwr |=> ((lsts & $past(lsts & ~wlo)) == $past(lsts & ~wlo))); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lwr && ((wlo & card_evt & LOCAL_MASK) != '0)) |=>
      ((lsts & $past(wlo & card_evt & LOCAL_MASK)) == $past(wlo & card_evt & LOCAL_MASK))); // R4
  AST_SUMMARY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((lsts & len) != '0) |=> gsts[0]); // R6
  AST_PEER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    peer_evt[0] |=> gsts[1]); // R7
  AST_IRQ_NEEDS_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gsig && gsts != '0)); // R10
  AST_IRQ_NEEDS_STATUS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !gse |-> !irq_o); // R10
endmodule

bind cardirq_hub cirq_chk #(
  .DATA_W(DATA_W), .LOCAL_W(LOCAL_W), .GLOBAL_W(GLOBAL_W), .LOCAL_MASK(LOCAL_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .card_evt(card_evt), .peer_evt(peer_evt), .irq_o(irq_o),
  .lsts(lsts), .len(len), .gsts(gsts), .gse(gse), .gsig(gsig)
);

// File: tb/tb_cardirq_hub.sv
`timescale 1ns/1ps
module tb_cardirq_hub;
  localparam logic [11:0] MASK = 12'hF0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] card_evt = '0;
  logic [0:0]  peer_evt = '0;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // bench model
  logic [11:0] m_ls = '0, m_le = '0;
  logic [1:0]  m_gs = '0;
  logic        m_gse = 1'b0, m_gsig = 1'b0;

  always #2.5 clk = ~clk;

  cardirq_hub dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_evt(card_evt),
    .peer_evt(peer_evt), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h004: return {20'd0, m_ls};
      12'h008: return {20'd0, m_le};
      12'h800: return m_gse ? {30'd0, m_gs} : 32'd0;
      12'h804: return {31'd0, m_gse};
      12'h808: return {31'd0, m_gsig};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_gs != 2'b00) && m_gse && m_gsig;
  endfunction

  task automatic cyc(input logic [11:0] ev, input logic pe, input logic wr,
                     input logic [11:0] a, input logic [31:0] wd);
    logic [11:0] n_ls, n_le;
    logic [1:0]  n_gs;
    logic        n_gse, n_gsig, pend;
    @(negedge clk);
    card_evt = ev; peer_evt = pe; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    total++;
    if (reg_rdata !== exp_read(a)) begin
      bad++;
      $display("FAIL %s read 0x%03h: got 0x%08h exp 0x%08h", tag, a, reg_rdata, exp_read(a));
    end
    total++;
    if (irq_o !== exp_irq()) begin
      bad++;
      $display("FAIL R10 irq_o: got %0b exp %0b", irq_o, exp_irq());
    end
    pend = (m_ls & m_le) != 12'd0;
    n_ls = (ev & MASK) | (m_ls & ~((wr && a == 12'h004) ? wd[11:0] : 12'd0));
    n_le = (wr && a == 12'h008) ? (wd[11:0] & MASK) : m_le;
    n_gs = {pe, pend} | (m_gs & ~((wr && a == 12'h800) ? wd[1:0] : 2'b00));
    n_gse  = (wr && a == 12'h804) ? wd[0] : m_gse;
    n_gsig = (wr && a == 12'h808) ? wd[0] : m_gsig;
    @(posedge clk);
    m_ls = n_ls; m_le = n_le; m_gs = n_gs; m_gse = n_gse; m_gsig = n_gsig;
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(12'd0, 1'b0, 1'b0, a, 32'd0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(12'd0, 1'b0, 1'b1, a, d);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    tag = "R1";
    rd(12'h004); rd(12'h008); rd(12'h800); rd(12'h804); rd(12'h808);

    tag = "R2";  // events latch without enable, only masked bits
    cyc(12'hFFF, 1'b0, 1'b0, 12'h004, 0);
    rd(12'h004); rd(12'h800);

    tag = "R3";  // clear low nibble only
    wr(12'h004, 32'hFFFF_F00F);
    rd(12'h004);

    tag = "R4";  // event and clear on bit 9 together
    cyc(12'h200, 1'b0, 1'b1, 12'h004, 32'h0000_0200);
    rd(12'h004);

    tag = "R5";
    wr(12'h008, 32'hFFFF_FFFF); rd(12'h008);
    wr(12'h008, 32'h0000_0401); rd(12'h008);

    tag = "R6";  // bit 10 enabled and pending
    wr(12'h804, 32'd1);
    rd(12'h800); rd(12'h800);
    wr(12'h800, 32'd1);          // clear while still pending: re-sets
    rd(12'h800);
    wr(12'h004, 32'h0000_0FFF);  // drop local
    rd(12'h800);
    wr(12'h800, 32'd1);
    rd(12'h800); rd(12'h800);

    tag = "R7";
    cyc(12'd0, 1'b1, 1'b0, 12'h800, 0);
    rd(12'h800);
    wr(12'h800, 32'd2); rd(12'h800);

    tag = "R8";
    cyc(12'd0, 1'b1, 1'b0, 12'h800, 0);
    wr(12'h804, 32'd0); rd(12'h800);

    tag = "R9";
    wr(12'h804, 32'hFFFF_FFFE); rd(12'h804);
    wr(12'h804, 32'd3); rd(12'h804);
    wr(12'h808, 32'd1); rd(12'h808);

    tag = "R10";
    rd(12'h000); wr(12'h808, 32'd0); rd(12'h000);
    wr(12'h808, 32'd1); rd(12'h000);
    wr(12'h800, 32'd3); rd(12'h000);

    tag = "R11";
    wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C);
    wr(12'h810, 32'hFFFF_FFFF); rd(12'h810);
    wr(12'h404, 32'hFFFF_FFFF); rd(12'h004); rd(12'h008);

    tag = "R3";  // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] ev, a;
      logic [31:0] d;
      logic w;
      ev = '0;
      for (int b = 0; b < 12; b++) ev[b] = ($urandom % 10) == 0;
      case ($urandom % 7)
        0: a = 12'h004; 1: a = 12'h008; 2: a = 12'h800;
        3: a = 12'h804; 4: a = 12'h808; 5: a = 12'h00C;
        default: a = 12'h800;
      endcase
      d = $urandom;
      w = ($urandom % 3) == 0;
      cyc(ev, ($urandom % 12) == 0, w, a, d);
    end

    finish_run();
  end
endmodule